// File: doc/BRIEF.md
# Daisy-Chained Bus Allocation Node

This block sits beside one processor core and decides when that core may use a system address and data bus that it shares with other processors. Up to three nodes share one active-low busy line. Every node pulls the line low while it claims the bus, and an external pull-up returns it high when no node pulls. A priority chain runs from node to node. Each node receives an active-low permit from the node above it. It passes the permit downward only while it is not claiming the bus itself.

The core raises a request and waits for a grant. A lock input from the core keeps ownership across both bus accesses of an increment-and-load or decrement-and-load instruction, so no other master can enter between the read and the write. The node also produces the enable for the core's bus drivers. That enable falls in the same cycle that the upstream permit is withdrawn.

The open-drain line is modelled by two signals. `line_pull_o` high means "drive the line low". `line_busy_n_i` is the level sampled on the wire.

Top module: `busalloc_node`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge) the node neither pulls the line nor grants the core, and the driver enable is low.
- R2: `chain_en_n_o` is low exactly when `chain_en_n_i` is low and `line_pull_o` is low; otherwise it is high.
- R3: When the core requests while the line is high and `chain_en_n_i` is low, `line_pull_o` rises after the next rising edge. `core_grant_o` rises one edge later if `chain_en_n_i` is still low.
- R4: While the line is held low by another master, a requesting node does not pull. It starts pulling on the first edge where the line is high and `chain_en_n_i` is low.
- R5: While `chain_en_n_i` is high, a requesting node does not pull.
- R6: With `core_lock_i` low, both `line_pull_o` and `core_grant_o` fall on the first edge at which `core_req_i` is sampled low.
- R7: While `core_lock_i` is high, a granted node keeps pulling and keeps its grant even if `core_req_i` is low.
- R8: `drv_en_o` equals `core_grant_o` AND NOT `chain_en_n_i`, with no clock delay.
- R9: If `chain_en_n_i` is high at the edge that would grant a node that is still pulling without a grant, the node stops pulling and gives no grant. It retries later if the core still requests.
- R10: `core_grant_o` is never high unless `line_pull_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_i | input | 1 | Core wants the bus |
| core_lock_i | input | 1 | Core keeps the bus across a read-modify-write |
| core_grant_o | output | 1 | Core owns the bus |
| line_busy_n_i | input | 1 | Sampled level of the shared busy line (low = busy) |
| line_pull_o | output | 1 | Pull the shared busy line low |
| chain_en_n_i | input | 1 | Permit from the upstream node (low = permitted) |
| chain_en_n_o | output | 1 | Permit to the downstream node (low = permitted) |
| drv_en_o | output | 1 | Enable for the core's bus drivers |

## Verification
A wrong internal state shows on `line_pull_o` and `core_grant_o` one edge after the stimulus that should have moved it. A node stuck claiming also keeps `chain_en_n_o` high, which starves every node below it. A node that claims too early pulls the line while another master holds it. A wrong grant path shows on `drv_en_o` at once, because that output combines the grant with the live permit and has no register in between. Each scenario is therefore checked cycle by cycle on all four outputs, starting from the first edge after the input change.

// File: rtl/busalloc_pkg.sv
package busalloc_pkg;

    typedef enum logic [1:0] {
        BA_IDLE  = 2'd0,
        BA_WAIT  = 2'd1,
        BA_CLAIM = 2'd2,
        BA_OWN   = 2'd3
    } ba_state_e;

    typedef struct packed {
        logic req;
        logic lock;
        logic line_free;
        logic chain_ok;
    } ba_sense_t;

    function automatic logic ba_may_claim(ba_sense_t s);
        return s.req & s.line_free & s.chain_ok;
    endfunction

    function automatic logic ba_keep(ba_sense_t s);
        return s.req | s.lock;
    endfunction

endpackage

// File: rtl/ba_claim_fsm.sv
module ba_claim_fsm
    import busalloc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ba_sense_t sense,
    output logic      pull_o,
    output logic      grant_o
);
    ba_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BA_IDLE: begin
                if (ba_may_claim(sense))   state_d = BA_CLAIM;
                else if (sense.req)        state_d = BA_WAIT;
            end
            BA_WAIT: begin
                if (!sense.req)              state_d = BA_IDLE;
                else if (ba_may_claim(sense)) state_d = BA_CLAIM;
            end
            BA_CLAIM: begin
                if (!sense.chain_ok)       state_d = sense.req ? BA_WAIT : BA_IDLE;
                else if (!ba_keep(sense))  state_d = BA_IDLE;
                else                       state_d = BA_OWN;
            end
            BA_OWN: begin
                if (!ba_keep(sense))       state_d = BA_IDLE;
            end
            default:                       state_d = BA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= BA_IDLE;
        else     state_q <= state_d;
    end

    assign pull_o  = (state_q == BA_CLAIM) || (state_q == BA_OWN);
    assign grant_o = (state_q == BA_OWN);

    // R4: no new claim while another master holds the line
    p_no_pull_when_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (!pull_o && !sense.line_free) |=> !pull_o);

    // R5: no claim while the upstream permit is withheld
    p_no_pull_without_permit_r5: assert property (@(posedge clk) disable iff (rst)
        (!pull_o && !sense.chain_ok) |=> !pull_o);

    // R3: a claim with the permit present is granted on the next edge
    p_grant_follows_claim_r3: assert property (@(posedge clk) disable iff (rst)
        (pull_o && !grant_o && sense.chain_ok && sense.req) |=> grant_o);

    // R6: release one edge after the request drops without lock
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (grant_o && !sense.req && !sense.lock) |=> (!pull_o && !grant_o));

    // R7: lock keeps ownership
    p_lock_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (grant_o && sense.lock) |=> (grant_o && pull_o));

    // R9: permit lost before grant withdraws the claim
    p_withdraw_r9: assert property (@(posedge clk) disable iff (rst)
        (pull_o && !grant_o && !sense.chain_ok) |=> (!pull_o && !grant_o));

endmodule

// File: rtl/ba_chain_gate.sv
module ba_chain_gate (
    input  logic chain_en_n_i,
    input  logic pull_i,
    input  logic grant_i,
    output logic chain_en_n_o,
    output logic drv_en_o
);
    logic permitted;

    assign permitted    = ~chain_en_n_i;
    assign chain_en_n_o = ~(permitted & ~pull_i);
    assign drv_en_o     = grant_i & permitted;

endmodule

// File: rtl/busalloc_node.sv
module busalloc_node
    import busalloc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic core_req_i,
    input  logic core_lock_i,
    output logic core_grant_o,
    input  logic line_busy_n_i,
    output logic line_pull_o,
    input  logic chain_en_n_i,
    output logic chain_en_n_o,
    output logic drv_en_o
);
    ba_sense_t sense;
    logic      pull, grant;

    assign sense.req       = core_req_i;
    assign sense.lock      = core_lock_i;
    assign sense.line_free = line_busy_n_i;
    assign sense.chain_ok  = ~chain_en_n_i;

    ba_claim_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .sense   (sense),
        .pull_o  (pull),
        .grant_o (grant)
    );

    ba_chain_gate u_gate (
        .chain_en_n_i (chain_en_n_i),
        .pull_i       (pull),
        .grant_i      (grant),
        .chain_en_n_o (chain_en_n_o),
        .drv_en_o     (drv_en_o)
    );

    assign line_pull_o  = pull;
    assign core_grant_o = grant;

    // R10: a grant is only held while the line is pulled
    p_grant_implies_pull_r10: assert property (@(posedge clk) disable iff (rst)
        core_grant_o |-> line_pull_o);

    // R2: a claiming node never passes the permit down
    p_no_pass_while_claiming_r2: assert property (@(posedge clk) disable iff (rst)
        line_pull_o |-> chain_en_n_o);

endmodule

// File: tb/busalloc_node_tb_top.sv
`timescale 1ns/1ps
module busalloc_node_tb_top;

    logic clk = 1'b0;
    logic rst;
    logic core_req, core_lock, chain_en_n, other_pull;
    logic core_grant, line_pull, chain_en_n_out, drv_en;
    logic line_busy_n;

    always #2.5 clk = ~clk;

    assign line_busy_n = ~(line_pull | other_pull);

    busalloc_node dut_i (
        .clk           (clk),
        .rst           (rst),
        .core_req_i    (core_req),
        .core_lock_i   (core_lock),
        .core_grant_o  (core_grant),
        .line_busy_n_i (line_busy_n),
        .line_pull_o   (line_pull),
        .chain_en_n_i  (chain_en_n),
        .chain_en_n_o  (chain_en_n_out),
        .drv_en_o      (drv_en)
    );

    typedef struct {
        string tag;
        logic  pull;
        logic  grant;
        logic  en_out;
        logic  drv;
    } exp_t;

    exp_t exp_q[$];
    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    task automatic cmp(string tag, string what, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // driver: apply inputs at the falling edge, push the outputs expected after the next rising edge
    task automatic step(string tag, logic r, logic rq, logic lk, logic en_n, logic oth,
                        logic e_pull, logic e_grant);
        exp_t e;
        @(negedge clk);
        rst = r; core_req = rq; core_lock = lk; chain_en_n = en_n; other_pull = oth;
        e.tag    = tag;
        e.pull   = e_pull;
        e.grant  = e_grant;
        e.en_out = ~(~en_n & ~e_pull);   // R2
        e.drv    = e_grant & ~en_n;      // R8
        exp_q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "line_pull",    line_pull,      e.pull);
                cmp(e.tag, "core_grant",   core_grant,     e.grant);
                cmp(e.tag, "chain_en_n_o", chain_en_n_out, e.en_out);
                cmp(e.tag, "drv_en",       drv_en,         e.drv);
                if (core_grant && !line_pull) begin
                    mismatched++;
                    $display("FAIL %s R10 grant=%b pull=%b expected pull=1", e.tag, core_grant, line_pull);
                end
            end
        end
    end

    initial begin
        rst = 1; core_req = 0; core_lock = 0; chain_en_n = 0; other_pull = 0;
        // R1 reset state
        step("R1 reset", 1, 0, 0, 0, 0, 0, 0);
        step("R1 reset", 1, 1, 0, 0, 0, 0, 0);
        step("R1 idle",  0, 0, 0, 0, 0, 0, 0);
        // R2 permit passes through when idle
        step("R2 permit high", 0, 0, 0, 1, 0, 0, 0);
        step("R2 permit low",  0, 0, 0, 0, 0, 0, 0);
        // R3 basic claim and grant, then R6 release
        step("R3 claim",  0, 1, 0, 0, 0, 1, 0);
        step("R3 grant",  0, 1, 0, 0, 0, 1, 1);
        step("R3 hold",   0, 1, 0, 0, 0, 1, 1);
        step("R6 release",0, 0, 0, 0, 0, 0, 0);
        // R4 line held by another master
        step("R4 busy wait", 0, 1, 0, 0, 1, 0, 0);
        step("R4 busy wait", 0, 1, 0, 0, 1, 0, 0);
        step("R4 line freed",0, 1, 0, 0, 0, 1, 0);
        step("R4 grant",     0, 1, 0, 0, 0, 1, 1);
        step("R6 release",   0, 0, 0, 0, 0, 0, 0);
        // R4 idle node never pulls when another holds the line
        step("R4 idle busy", 0, 0, 0, 0, 1, 0, 0);
        step("R4 idle free", 0, 0, 0, 0, 0, 0, 0);
        // R5 no permit
        step("R5 no permit", 0, 1, 0, 1, 0, 0, 0);
        step("R5 no permit", 0, 1, 0, 1, 0, 0, 0);
        step("R5 permit",    0, 1, 0, 0, 0, 1, 0);
        step("R5 grant",     0, 1, 0, 0, 0, 1, 1);
        step("R6 release",   0, 0, 0, 0, 0, 0, 0);
        // R7 lock across read-modify-write
        step("R7 claim",   0, 1, 0, 0, 0, 1, 0);
        step("R7 grant",   0, 1, 1, 0, 0, 1, 1);
        step("R7 locked",  0, 0, 1, 0, 0, 1, 1);
        step("R7 locked",  0, 0, 1, 0, 0, 1, 1);
        step("R7 unlock",  0, 0, 0, 0, 0, 0, 0);
        // R9 permit lost before grant
        step("R9 claim",    0, 1, 0, 0, 0, 1, 0);
        step("R9 withdraw", 0, 1, 0, 1, 0, 0, 0);
        step("R9 retry",    0, 1, 0, 0, 0, 1, 0);
        step("R9 grant",    0, 1, 0, 0, 0, 1, 1);
        // R8 permit lost while granted: drivers off at once, grant kept
        step("R8 permit lost",  0, 1, 0, 1, 0, 1, 1);
        step("R8 permit back",  0, 1, 0, 0, 0, 1, 1);
        step("R6 release",      0, 0, 0, 0, 0, 0, 0);
        // request withdrawn while waiting
        step("R4 wait",    0, 1, 0, 0, 1, 0, 0);
        step("R4 abandon", 0, 0, 0, 0, 0, 0, 0);
        step("R4 stay idle",0, 0, 0, 0, 0, 0, 0);
        // reset while owning
        step("R7 claim", 0, 1, 1, 0, 0, 1, 0);
        step("R7 grant", 0, 1, 1, 0, 0, 1, 1);
        step("R1 reset in use", 1, 1, 1, 0, 0, 0, 0);
        step("R1 after reset",  0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule